// File: doc/BRIEF.md
# Four-Entry Master Data Holding Buffer

This block is a small first-in first-out holding store of four bytes that sits between a processor register port and an I2C master transfer engine. The processor pushes bytes to be sent, or pulls received bytes, through a single data register address. The block reports two status flags: one shows that at least one byte is held and the other shows that all four slots are taken. The transfer engine uses the same store. While it owns the buffer it drains bytes for a write transfer or deposits bytes for a read transfer, and processor data accesses are ignored.

Fill level is tracked by a last-valid index that runs from -1 (nothing held) to 3 (all four held). A pop always takes slot 0 and moves every remaining slot one place toward the head. A push lands at the slot just past the current index. A mode-control register write keeps only the bits of mask 0x3d. When bit 6 of that write is set, the write flushes the store instead of retaining the bit.

Occupancy is a three-state machine: ST_EMPTY, ST_PARTIAL and ST_FULL. Its transitions are:
- first-in: ST_EMPTY to ST_PARTIAL.
- top-off: ST_PARTIAL to ST_FULL.
- drain: ST_FULL to ST_PARTIAL.
- last-out: ST_PARTIAL to ST_EMPTY.
- flush: any state to ST_EMPTY.

Each cycle is classified as one of these operations: OP_NONE, OP_POP, OP_PUSH, OP_BOTH (pop then push) or OP_FLUSH.

Top module: `mdata_buffer`

## Requirements
- R1: After reset the store holds nothing: has_data and full are low, head_data, cpu_rdata and mode_q are all 0x00, and all four slots are zero.
- R2: A push is stored at the slot after the last valid one when fewer than four bytes are held. A push made while four bytes are held is dropped and leaves the contents unchanged.
- R3: has_data rises when a push brings the index from -1 to 0. full rises when a push brings the index to 3. full is never high while has_data is low.
- R4: An accepted processor read puts slot 0 on cpu_rdata on the next clock edge, shifts the remaining bytes one slot toward the head and lowers the index by one. head_data always shows slot 0.
- R5: A pop taken at index 3 clears full. A pop taken at index 0 clears has_data.
- R6: A processor read while nothing is held returns 0x00 and leaves the flags and contents unchanged.
- R7: A mode write with bit 6 set empties the store, zeroes every slot and clears both flags. Any push or pop requested in the same cycle is discarded, and cpu_rdata is not updated.
- R8: A mode write loads mode_q with the written byte ANDed with 0x3d, so bit 6 never reads back as set. Mode writes without bit 6 leave the store untouched.
- R9: When a pop and a push are requested in the same cycle, the pop is applied first. At index 3 the pop frees a slot and the new byte is kept, and full stays high. At index -1 the read returns 0x00 and the byte is stored.
- R10: While eng_own is high, only eng_push/eng_pdata and eng_pop act on the store, and processor reads and writes have no effect on it.
- R11: cpu_rdata holds its value until the next accepted processor read. Engine pops do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Processor write to the data register |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rd | input | 1 | Processor read of the data register |
| cpu_rdata | output | 8 | Byte returned by the last accepted processor read |
| mode_wr | input | 1 | Mode-control register write |
| mode_wdata | input | 8 | Mode-control write value; bit 6 flushes the store |
| mode_q | output | 8 | Retained mode-control bits (mask 0x3d) |
| eng_own | input | 1 | Transfer engine owns the store |
| eng_push | input | 1 | Engine deposits a received byte |
| eng_pdata | input | 8 | Byte deposited by the engine |
| eng_pop | input | 1 | Engine takes slot 0 for transmission |
| head_data | output | 8 | Current slot 0 |
| has_data | output | 1 | At least one byte held |
| full | output | 1 | Four bytes held |

## Verification
The assertions check these relations on every cycle:
- full implies has_data.
- A read returns the previous head byte.
- A push into a full store leaves the head and full in place.
- A flush leaves the store empty with zero head.
- mode_q equals the masked write.
- cpu_rdata is stable without a read.
- An idle engine cycle leaves the store frozen.

Only the bench's scenarios show the first-in order across a full fill and drain, the shift that brings each later byte to the head, the pop-before-push order at both the full and empty edges, flush winning over a same-cycle push, and processor accesses being ignored while the engine owns the store.

// File: rtl/mdb_pkg.sv
package mdb_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_PARTIAL,
        ST_FULL
    } occ_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_POP,
        OP_PUSH,
        OP_BOTH,
        OP_FLUSH
    } op_e;

endpackage

// File: rtl/mdb_mode.sv
module mdb_mode #(
    parameter int          DW        = 8,
    parameter int          FLUSH_BIT = 6,
    parameter logic [7:0]  KEEP_MASK = 8'h3d
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr,
    input  logic [DW-1:0] mode_wdata,
    output logic [DW-1:0] mode_q,
    output logic          flush
);
    localparam logic [DW-1:0] MASK_W = DW'(KEEP_MASK);

    // flush is a one-cycle command, never stored
    assign flush = mode_wr && mode_wdata[FLUSH_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q <= mode_wdata & MASK_W;
        end
    end
endmodule

// File: rtl/mdb_arbiter.sv
module mdb_arbiter
    import mdb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          eng_own,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          eng_pop,
    input  logic          eng_push,
    input  logic [DW-1:0] eng_pdata,
    input  logic          flush,
    output op_e           op,
    output logic [DW-1:0] push_data,
    output logic          cpu_take
);
    logic rd_req;
    logic wr_req;

    always_comb begin
        rd_req    = eng_own ? eng_pop   : cpu_rd;
        wr_req    = eng_own ? eng_push  : cpu_wr;
        push_data = eng_own ? eng_pdata : cpu_wdata;
        cpu_take  = !eng_own && cpu_rd && !flush;
        if (flush) begin
            op = OP_FLUSH;
        end else begin
            unique case ({rd_req, wr_req})
                2'b00:   op = OP_NONE;
                2'b10:   op = OP_POP;
                2'b01:   op = OP_PUSH;
                default: op = OP_BOTH;
            endcase
        end
    end
endmodule

// File: rtl/mdb_ctrl.sv
module mdb_ctrl
    import mdb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int IDX_W = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  op_e           op,
    output logic          pop_ok,
    output logic          push_ok,
    output logic [AW-1:0] wpos,
    output occ_e          occ_q,
    output logic          has_q,
    output logic          full_q
);
    localparam logic [IDX_W-1:0] EMPTY_IDX = {IDX_W{1'b1}};
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DEPTH - 1);
    localparam logic [IDX_W-1:0] ONE       = IDX_W'(1);

    logic [IDX_W-1:0] idx_q, idx_pop, idx_nxt;
    occ_e             occ_d;
    logic             has_d, full_d;

    // acceptance and next index: pop is applied before push
    always_comb begin
        pop_ok  = 1'b0;
        push_ok = 1'b0;
        unique case (op)
            OP_NONE, OP_FLUSH: ;
            OP_POP:  pop_ok = (occ_q != ST_EMPTY);
            OP_PUSH: push_ok = (occ_q != ST_FULL);
            OP_BOTH: begin
                pop_ok  = (occ_q != ST_EMPTY);
                push_ok = pop_ok || (occ_q != ST_FULL);
            end
            default: ;
        endcase
        idx_pop = pop_ok  ? idx_q - ONE   : idx_q;
        idx_nxt = push_ok ? idx_pop + ONE : idx_pop;
        if (op == OP_FLUSH) begin
            idx_nxt = EMPTY_IDX;
        end
        wpos = idx_nxt[AW-1:0];
    end

    // occupancy next state
    always_comb begin
        occ_d = occ_q;
        unique case (occ_q)
            ST_EMPTY: begin
                if (idx_nxt == LAST_IDX)       occ_d = ST_FULL;
                else if (idx_nxt != EMPTY_IDX) occ_d = ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (idx_nxt == EMPTY_IDX)      occ_d = ST_EMPTY;
                else if (idx_nxt == LAST_IDX)  occ_d = ST_FULL;
            end
            ST_FULL: begin
                if (idx_nxt == EMPTY_IDX)      occ_d = ST_EMPTY;
                else if (idx_nxt != LAST_IDX)  occ_d = ST_PARTIAL;
            end
            default: occ_d = ST_EMPTY;
        endcase
    end

    // flag outputs: change only at named index transitions
    always_comb begin
        has_d  = has_q;
        full_d = full_q;
        if (op == OP_FLUSH) begin
            has_d  = 1'b0;
            full_d = 1'b0;
        end else begin
            if (pop_ok && idx_q == LAST_IDX)  full_d = 1'b0;
            if (pop_ok && idx_q == '0)        has_d  = 1'b0;
            if (push_ok && idx_nxt == LAST_IDX) full_d = 1'b1;
            if (push_ok && idx_nxt == '0)     has_d  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q  <= ST_EMPTY;
            idx_q  <= EMPTY_IDX;
            has_q  <= 1'b0;
            full_q <= 1'b0;
        end else begin
            occ_q  <= occ_d;
            idx_q  <= idx_nxt;
            has_q  <= has_d;
            full_q <= full_d;
        end
    end
endmodule

// File: rtl/mdb_store.sv
module mdb_store #(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          pop,
    input  logic          push,
    input  logic [AW-1:0] wpos,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head
);
    logic [DW-1:0] slot [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        logic [DW-1:0] cell_q;
        logic [DW-1:0] shifted;

        if (k == DEPTH - 1) begin : g_tail
            assign shifted = pop ? '0 : cell_q;
        end else begin : g_body
            assign shifted = pop ? slot[k+1] : cell_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else if (flush) begin
                cell_q <= '0;
            end else if (push && wpos == AW'(k)) begin
                cell_q <= wdata;
            end else begin
                cell_q <= shifted;
            end
        end

        assign slot[k] = cell_q;
    end

    assign head = slot[0];
endmodule

// File: rtl/mdata_buffer.sv
module mdata_buffer
    import mdb_pkg::*;
#(
    parameter int         DEPTH     = 4,
    parameter int         DW        = 8,
    parameter int         FLUSH_BIT = 6,
    parameter logic [7:0] KEEP_MASK = 8'h3d
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_rd,
    output logic [DW-1:0] cpu_rdata,
    input  logic          mode_wr,
    input  logic [DW-1:0] mode_wdata,
    output logic [DW-1:0] mode_q,
    input  logic          eng_own,
    input  logic          eng_push,
    input  logic [DW-1:0] eng_pdata,
    input  logic          eng_pop,
    output logic [DW-1:0] head_data,
    output logic          has_data,
    output logic          full
);
    localparam int AW = $clog2(DEPTH);

    logic          flush;
    op_e           op;
    logic [DW-1:0] push_data;
    logic          cpu_take;
    logic          pop_ok, push_ok;
    logic [AW-1:0] wpos;
    occ_e          occ_q;
    logic          has_q, full_q;

    mdb_mode #(.DW(DW), .FLUSH_BIT(FLUSH_BIT), .KEEP_MASK(KEEP_MASK)) u_mode (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .mode_q(mode_q), .flush(flush)
    );

    mdb_arbiter #(.DW(DW)) u_arb (
        .eng_own(eng_own), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .eng_pop(eng_pop), .eng_push(eng_push), .eng_pdata(eng_pdata),
        .flush(flush), .op(op), .push_data(push_data), .cpu_take(cpu_take)
    );

    mdb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .op(op), .pop_ok(pop_ok), .push_ok(push_ok),
        .wpos(wpos), .occ_q(occ_q), .has_q(has_q), .full_q(full_q)
    );

    mdb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pop(pop_ok), .push(push_ok),
        .wpos(wpos), .wdata(push_data), .head(head_data)
    );

    // processor read return register; an empty read yields zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_rdata <= '0;
        end else if (cpu_take) begin
            cpu_rdata <= (occ_q != ST_EMPTY) ? head_data : '0;
        end
    end

    assign has_data = has_q;
    assign full     = full_q;
endmodule

// File: rtl/mdb_chk.sv
module mdb_chk #(
    parameter int         DW        = 8,
    parameter int         FLUSH_BIT = 6,
    parameter logic [7:0] KEEP_MASK = 8'h3d
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_wr,
    input logic          cpu_rd,
    input logic [DW-1:0] cpu_rdata,
    input logic          mode_wr,
    input logic [DW-1:0] mode_wdata,
    input logic [DW-1:0] mode_q,
    input logic          eng_own,
    input logic          eng_push,
    input logic          eng_pop,
    input logic [DW-1:0] head_data,
    input logic          has_data,
    input logic          full
);
    logic fl;
    assign fl = mode_wr && mode_wdata[FLUSH_BIT];

    p_full_has_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> has_data);

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_own && cpu_wr && !cpu_rd && full && !fl)
        |=> (full && head_data == $past(head_data)));

    p_read_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_own && cpu_rd && !fl) |=> (cpu_rdata == $past(head_data)));

    p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_own && cpu_rd && !cpu_wr && !has_data && !fl)
        |=> (cpu_rdata == '0 && !has_data && !full));

    p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fl |=> (!has_data && !full && head_data == '0));

    p_mode_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (mode_q == ($past(mode_wdata) & DW'(KEEP_MASK))));

    p_engine_own_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_own && !eng_push && !eng_pop && !fl)
        |=> ($stable(has_data) && $stable(full) && $stable(head_data)));

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!eng_own && cpu_rd) |=> $stable(cpu_rdata));
endmodule

bind mdata_buffer mdb_chk #(.DW(DW), .FLUSH_BIT(FLUSH_BIT), .KEEP_MASK(KEEP_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_rdata(cpu_rdata), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .mode_q(mode_q), .eng_own(eng_own), .eng_push(eng_push), .eng_pop(eng_pop),
    .head_data(head_data), .has_data(has_data), .full(full)
);

// File: tb/sim_mdata_buffer.sv
module sim_mdata_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 0, cpu_rd = 0, mode_wr = 0, eng_own = 0, eng_push = 0, eng_pop = 0;
    logic [7:0] cpu_wdata = 0, mode_wdata = 0, eng_pdata = 0;
    logic [7:0] cpu_rdata, mode_q, head_data;
    logic       has_data, full;

    always #10 clk = ~clk;

    mdata_buffer u0 (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .mode_q(mode_q), .eng_own(eng_own),
        .eng_push(eng_push), .eng_pdata(eng_pdata), .eng_pop(eng_pop),
        .head_data(head_data), .has_data(has_data), .full(full)
    );

    typedef struct {
        string      tag;
        logic [7:0] rdata;
        logic [7:0] mode;
        logic [7:0] head;
        logic       has;
        logic       fl;
    } exp_t;

    exp_t       expq[$];
    logic [7:0] mq[$];
    logic [7:0] m_rdata = 0;
    logic [7:0] m_mode = 0;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 0;

    task automatic compare(input exp_t e);
        n_chk++;
        if (cpu_rdata !== e.rdata || mode_q !== e.mode || head_data !== e.head ||
            has_data !== e.has || full !== e.fl) begin
            n_fail++;
            $display("FAIL %s: rdata=%h mode=%h head=%h has=%b full=%b exp rdata=%h mode=%h head=%h has=%b full=%b",
                     e.tag, cpu_rdata, mode_q, head_data, has_data, full,
                     e.rdata, e.mode, e.head, e.has, e.fl);
        end
    endtask

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        if (expq.size() > 0) compare(expq.pop_front());
    end

    // driver: one cycle of stimulus, then push the expected outcome
    task automatic step(input string tag,
                        input logic c_rd, input logic c_wr, input logic [7:0] c_wd,
                        input logic m_wr, input logic [7:0] m_wd,
                        input logic e_own, input logic e_push, input logic [7:0] e_pd,
                        input logic e_pop);
        logic rd, wr;
        logic [7:0] wd;
        exp_t e;
        @(negedge clk);
        cpu_rd = c_rd; cpu_wr = c_wr; cpu_wdata = c_wd;
        mode_wr = m_wr; mode_wdata = m_wd;
        eng_own = e_own; eng_push = e_push; eng_pdata = e_pd; eng_pop = e_pop;
        @(posedge clk);
        #1;
        cpu_rd = 0; cpu_wr = 0; mode_wr = 0; eng_push = 0; eng_pop = 0; eng_own = 0;
        if (m_wr) m_mode = m_wd & 8'h3d;
        if (m_wr && m_wd[6]) begin
            mq.delete();
        end else begin
            rd = e_own ? e_pop : c_rd;
            wr = e_own ? e_push : c_wr;
            wd = e_own ? e_pd : c_wd;
            if (rd) begin
                if (!e_own) m_rdata = (mq.size() > 0) ? mq[0] : 8'h00;
                if (mq.size() > 0) void'(mq.pop_front());
            end
            if (wr && mq.size() < 4) mq.push_back(wd);
        end
        e.tag = tag; e.rdata = m_rdata; e.mode = m_mode;
        e.head = (mq.size() > 0) ? mq[0] : 8'h00;
        e.has = mq.size() > 0; e.fl = mq.size() == 4;
        expq.push_back(e);
    endtask

    task automatic wr_b(input string tag, input logic [7:0] d);
        step(tag, 0, 1, d, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic rd_b(input string tag);
        step(tag, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;   // R1 reset state
        if (cpu_rdata !== 0 || mode_q !== 0 || head_data !== 0 || has_data !== 0 || full !== 0) begin
            n_fail++;
            $display("FAIL R1 reset: rdata=%h mode=%h head=%h has=%b full=%b exp all zero",
                     cpu_rdata, mode_q, head_data, has_data, full);
        end
        rst_n = 1'b1;

        wr_b("R3 first push sets has_data", 8'ha1);
        wr_b("R2 second push", 8'hb2);
        wr_b("R2 third push", 8'hc3);
        wr_b("R3 fourth push sets full", 8'hd4);
        wr_b("R2 push while full dropped", 8'he5);
        rd_b("R5 pop from full clears full, R4 shift");
        step("R9 pop then push same cycle", 1, 1, 8'hf6, 0, 0, 0, 0, 0, 0);
        wr_b("R3 refill to full", 8'h07);
        step("R9 pop+push at full keeps full", 1, 1, 8'h08, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) rd_b("R4 drain in order, R5 last clears has");
        rd_b("R6 empty read returns zero");
        step("R9 pop+push at empty", 1, 1, 8'h5a, 0, 0, 0, 0, 0, 0);
        wr_b("R2 push after empty", 8'h6b);
        step("R7 flush beats same-cycle push", 0, 1, 8'h77, 1, 8'hff, 0, 0, 0, 0);
        step("R11 flush with read leaves rdata", 1, 0, 0, 1, 8'h40, 0, 0, 0, 0);
        wr_b("R2 push after flush", 8'h3c);
        step("R8 mode write without flush", 0, 0, 0, 1, 8'h97, 0, 0, 0, 0);
        step("R10 cpu write ignored while engine owns", 0, 1, 8'h99, 0, 0, 1, 0, 0, 0);
        step("R10 cpu read ignored while engine owns", 1, 0, 0, 0, 0, 1, 0, 0, 0);
        step("R10 engine push", 0, 0, 0, 0, 0, 1, 1, 8'h9a, 0);
        step("R11 engine pop keeps rdata", 0, 0, 0, 0, 0, 1, 0, 0, 1);
        rd_b("R4 read after engine pop");
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 5; k++) wr_b("R2 pattern fill", 8'(r * 37 + k * 11 + 1));
            for (int k = 0; k < 5; k++) rd_b("R4 pattern drain");
        end
        step("R1 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, all requirements unconfirmed");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule